// File: doc/BRIEF.md
# Daisy-Chain Token Readout Controller

This block runs one front-end chip in a chain of chips that share a single serial data line. Each chip goes through the same round: it acquires hits, converts them, waits for the readout token, sends its stored events and then sits idle. For each phase it raises a separate power-pulsing enable, so the analog and digital parts draw current only while their phase is running. Acquisition and conversion take about 1.5 ms of a cycle of about 200 ms, so the chip is active roughly 1% of the time.

During acquisition, each hit word is stored in a small event memory, up to a fixed depth. The start-of-readout input is the token. Once conversion has finished, the token makes the chip shift its stored words out onto the shared line, most significant bit first. After the last bit the chip pulses end-of-readout, which becomes the start-of-readout of the next chip. The shared line is treated as an open-collector wire. The chip asserts `transmit_on` only while it owns the line and holds its data output low at all other times. A chip with no events passes the token on at once.

Top module: `chain_readout_ctrl`

## Requirements
- R1: After reset, all three power enables, `transmit_on`, `end_readout` and `data_out` are 0 and the chip is idle.
- R2: A `start_acq` pulse taken while idle raises `pwr_acq` on the next cycle, with the other enables at 0. It also empties the event store.
- R3: A `start_conv` pulse taken during acquisition lowers `pwr_acq` and holds `pwr_conv` high for exactly CONV_CYC cycles. After that `pwr_ro` rises and the chip waits for the token. `start_conv` has no effect outside acquisition.
- R4: A `hit_valid` pulse stores `hit_word` only during acquisition. The store keeps the first DEPTH hits of a round and drops any later ones.
- R5: A token (`start_readout`) taken while waiting makes `transmit_on` rise on the next cycle. The stored words then appear on `data_out` in arrival order, each one MSB first, as N*EVT_W consecutive bits with `transmit_on` high for exactly those cycles.
- R6: While `transmit_on` is 0, `data_out` is 0, so the shared wire is released.
- R7: `end_readout` is high for exactly one cycle, the cycle right after the last bit. On the cycle after that the chip is idle with all enables at 0.
- R8: If the store is empty, a token makes `end_readout` pulse on the next cycle and `transmit_on` never rises.
- R9: A token that arrives during conversion is held. Transmission then starts on the cycle after `pwr_ro` rises.
- R10: `start_acq` is ignored in every phase except idle, and `start_readout` is ignored during idle and acquisition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_acq | input | 1 | Starts an acquisition phase |
| start_conv | input | 1 | Ends acquisition and starts conversion |
| start_readout | input | 1 | Token in from the previous chip |
| hit_valid | input | 1 | Strobe that carries a hit word |
| hit_word | input | EVT_W | Event word to store |
| pwr_acq | output | 1 | Power enable for acquisition |
| pwr_conv | output | 1 | Power enable for conversion |
| pwr_ro | output | 1 | Power enable for readout logic |
| transmit_on | output | 1 | High while `data_out` carries valid bits |
| data_out | output | 1 | Serial data, held low when the line is released |
| end_readout | output | 1 | One-cycle token out to the next chip |

## Verification
The bench covers four corner cases:
- **Hits beyond DEPTH.** A store that overflowed or wrapped would send too many words, or would overwrite the first ones.
- **A token that arrives during conversion.** A controller that dropped it would hang the chain, because `end_readout` would never be pulsed.
- **An empty store.** Missing the pass-through would either block the chain or put garbage words on the bus.
- **Stray starts.** A `start_acq` during readout, a `start_readout` while idle, and a `start_conv` while idle are all applied. A controller that obeyed them would cut the bit stream short, raise the wrong enable, or send a false token to the next chip.

// File: rtl/ro_pkg.sv
package ro_pkg;
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_ACQ   = 3'd1,
    PH_CONV  = 3'd2,
    PH_READY = 3'd3,
    PH_SEND  = 3'd4,
    PH_PASS  = 3'd5
  } ro_phase_e;
endpackage

// File: rtl/ro_event_store.sv
module ro_event_store #(
  parameter int EVT_W = 8,
  parameter int DEPTH = 4,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             acq_open,
  input  logic             hit_valid,
  input  logic [EVT_W-1:0] hit_word,
  input  logic [AW-1:0]    rd_addr,
  output logic [EVT_W-1:0] rd_q,
  output logic [CNT_W-1:0] count
);
  logic [EVT_W-1:0] mem [DEPTH];
  logic             wr_ok;

  assign wr_ok = acq_open && hit_valid && (count < CNT_W'(DEPTH));

  always_ff @(posedge clk) begin
    if (wr_ok) mem[count[AW-1:0]] <= hit_word;
    rd_q <= mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) count <= '0;
    else if (wr_ok) count <= count + 1'b1;
  end

  assert_count_cap_R4: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_W'(DEPTH));
  assert_closed_store_R4: assert property (@(posedge clk) disable iff (rst)
    (!acq_open && !clr) |=> $stable(count));
endmodule

// File: rtl/ro_serializer.sv
module ro_serializer #(
  parameter int EVT_W = 8,
  parameter int DEPTH = 4,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int BW = (EVT_W > 1) ? $clog2(EVT_W) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  logic [CNT_W-1:0] n_words,
  input  logic [EVT_W-1:0] rd_q,
  output logic [AW-1:0]    rd_addr,
  output logic             busy,
  output logic             last_bit,
  output logic             bit_out
);
  logic [EVT_W-1:0] shreg;
  logic [BW-1:0]    bit_cnt;
  logic [CNT_W-1:0] words_left;

  assign last_bit = busy && (bit_cnt == '0) && (words_left == '0);
  assign bit_out  = busy ? shreg[EVT_W-1] : 1'b0;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy       <= 1'b0;
      shreg      <= '0;
      bit_cnt    <= '0;
      words_left <= '0;
      rd_addr    <= '0;
    end else if (go && !busy) begin
      busy       <= 1'b1;
      shreg      <= rd_q;
      bit_cnt    <= BW'(EVT_W - 1);
      words_left <= n_words - 1'b1;
      rd_addr    <= AW'(1);
    end else if (busy) begin
      if (bit_cnt != '0) begin
        shreg   <= shreg << 1;
        bit_cnt <= bit_cnt - 1'b1;
      end else if (words_left == '0) begin
        busy    <= 1'b0;
        rd_addr <= '0;
      end else begin
        shreg      <= rd_q;
        bit_cnt    <= BW'(EVT_W - 1);
        words_left <= words_left - 1'b1;
        rd_addr    <= rd_addr + 1'b1;
      end
    end
  end

  assert_go_starts_R5: assert property (@(posedge clk) disable iff (rst)
    (go && !busy) |=> busy);
  assert_last_stops_R7: assert property (@(posedge clk) disable iff (rst)
    last_bit |=> !busy);
endmodule

// File: rtl/ro_phase_fsm.sv
module ro_phase_fsm
  import ro_pkg::*;
#(
  parameter int DEPTH    = 4,
  parameter int CONV_CYC = 4,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int CV_W  = (CONV_CYC > 1) ? $clog2(CONV_CYC) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_acq,
  input  logic             start_conv,
  input  logic             start_readout,
  input  logic [CNT_W-1:0] n_events,
  input  logic             ser_busy,
  input  logic             ser_last,
  output logic             acq_clear,
  output logic             acq_open,
  output logic             ser_go,
  output logic             pwr_acq,
  output logic             pwr_conv,
  output logic             pwr_ro,
  output logic             end_ro
);
  ro_phase_e       state, state_nx;
  logic [CV_W-1:0] conv_cnt;
  logic            tok_pend;
  logic            tok_go;

  assign tok_go    = (state == PH_READY) && (start_readout || tok_pend);
  assign ser_go    = tok_go && (n_events != '0);
  assign acq_clear = (state == PH_IDLE) && start_acq;
  assign acq_open  = (state == PH_ACQ);
  assign pwr_acq   = (state == PH_ACQ);
  assign pwr_conv  = (state == PH_CONV);
  assign pwr_ro    = (state == PH_READY) || (state == PH_SEND) || (state == PH_PASS);
  assign end_ro    = (state == PH_PASS);

  always_comb begin
    state_nx = state;
    unique case (state)
      PH_IDLE:  if (start_acq) state_nx = PH_ACQ;
      PH_ACQ:   if (start_conv) state_nx = PH_CONV;
      PH_CONV:  if (conv_cnt == '0) state_nx = PH_READY;
      PH_READY: if (tok_go) state_nx = (n_events == '0) ? PH_PASS : PH_SEND;
      PH_SEND:  if (ser_last) state_nx = PH_PASS;
      PH_PASS:  state_nx = PH_IDLE;
      default:  state_nx = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= PH_IDLE;
      conv_cnt <= '0;
      tok_pend <= 1'b0;
    end else begin
      state <= state_nx;
      if (state == PH_ACQ && start_conv) conv_cnt <= CV_W'(CONV_CYC - 1);
      else if (state == PH_CONV && conv_cnt != '0) conv_cnt <= conv_cnt - 1'b1;
      if (state == PH_CONV && start_readout) tok_pend <= 1'b1;
      else if (state != PH_CONV) tok_pend <= 1'b0;
    end
  end

  assert_bus_owner_R5: assert property (@(posedge clk) disable iff (rst)
    ser_busy |-> (state == PH_SEND));
  assert_end_single_R7: assert property (@(posedge clk) disable iff (rst)
    end_ro |=> !end_ro);
  assert_acq_locked_R10: assert property (@(posedge clk) disable iff (rst)
    (state != PH_IDLE && state != PH_ACQ) |=> (state != PH_ACQ));
  assert_conv_exit_R3: assert property (@(posedge clk) disable iff (rst)
    (state == PH_CONV && conv_cnt == '0) |=> (state == PH_READY));
endmodule

// File: rtl/chain_readout_ctrl.sv
module chain_readout_ctrl #(
  parameter int EVT_W    = 8,
  parameter int DEPTH    = 4,
  parameter int CONV_CYC = 4,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_acq,
  input  logic             start_conv,
  input  logic             start_readout,
  input  logic             hit_valid,
  input  logic [EVT_W-1:0] hit_word,
  output logic             pwr_acq,
  output logic             pwr_conv,
  output logic             pwr_ro,
  output logic             transmit_on,
  output logic             data_out,
  output logic             end_readout
);
  logic             acq_clear, acq_open, ser_go, ser_busy, ser_last;
  logic [EVT_W-1:0] rd_q;
  logic [AW-1:0]    rd_addr;
  logic [CNT_W-1:0] n_events;

  ro_phase_fsm #(.DEPTH(DEPTH), .CONV_CYC(CONV_CYC)) u_fsm (
    .clk(clk), .rst(rst), .start_acq(start_acq), .start_conv(start_conv),
    .start_readout(start_readout), .n_events(n_events), .ser_busy(ser_busy),
    .ser_last(ser_last), .acq_clear(acq_clear), .acq_open(acq_open),
    .ser_go(ser_go), .pwr_acq(pwr_acq), .pwr_conv(pwr_conv), .pwr_ro(pwr_ro),
    .end_ro(end_readout)
  );

  ro_event_store #(.EVT_W(EVT_W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst(rst), .clr(acq_clear), .acq_open(acq_open),
    .hit_valid(hit_valid), .hit_word(hit_word), .rd_addr(rd_addr),
    .rd_q(rd_q), .count(n_events)
  );

  ro_serializer #(.EVT_W(EVT_W), .DEPTH(DEPTH)) u_ser (
    .clk(clk), .rst(rst), .go(ser_go), .n_words(n_events), .rd_q(rd_q),
    .rd_addr(rd_addr), .busy(ser_busy), .last_bit(ser_last), .bit_out(data_out)
  );

  assign transmit_on = ser_busy;

  assert_params_R5: assert property (@(posedge clk) (EVT_W >= 2) && (DEPTH >= 2) && (CONV_CYC >= 2));
  assert_released_R6: assert property (@(posedge clk) disable iff (rst)
    (pwr_acq || pwr_conv) |-> !transmit_on);
endmodule

// File: tb/chain_readout_ctrl_test.sv
module chain_readout_ctrl_test;
  localparam int EVT_W = 8;
  localparam int DEPTH = 4;
  localparam int CONV_CYC = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_acq = 1'b0, start_conv = 1'b0, start_readout = 1'b0, hit_valid = 1'b0;
  logic [EVT_W-1:0] hit_word = '0;
  logic pwr_acq, pwr_conv, pwr_ro, transmit_on, data_out, end_readout;

  chain_readout_ctrl #(.EVT_W(EVT_W), .DEPTH(DEPTH), .CONV_CYC(CONV_CYC)) uut (
    .clk(clk), .rst(rst), .start_acq(start_acq), .start_conv(start_conv),
    .start_readout(start_readout), .hit_valid(hit_valid), .hit_word(hit_word),
    .pwr_acq(pwr_acq), .pwr_conv(pwr_conv), .pwr_ro(pwr_ro),
    .transmit_on(transmit_on), .data_out(data_out), .end_readout(end_readout)
  );

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0, cycles = 0;
  bit exp_q[$];
  int sess_bits = 0, sess_tx = 0;
  int stored = 0;
  bit acq_model = 1'b0;
  bit prev_tx = 1'b0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic do_start_acq();
    start_acq = 1'b1; tick(); start_acq = 1'b0;
    acq_model = 1'b1; stored = 0; sess_bits = 0; sess_tx = 0;
  endtask

  task automatic do_hit(input logic [EVT_W-1:0] w);
    hit_valid = 1'b1; hit_word = w; tick(); hit_valid = 1'b0;
    if (acq_model && stored < DEPTH) begin
      stored++;
      for (int b = EVT_W - 1; b >= 0; b--) begin
        exp_q.push_back(w[b]);
        sess_bits++;
      end
    end
  endtask

  task automatic do_conv(input bit token_mid);
    start_conv = 1'b1; tick(); start_conv = 1'b0; acq_model = 1'b0;
    chk(pwr_conv && !pwr_acq && !pwr_ro, "R3", "conv enable on entry", pwr_conv, 1);
    for (int i = 1; i < CONV_CYC; i++) begin
      if (token_mid && i == 1) begin start_readout = 1'b1; tick(); start_readout = 1'b0; end
      else tick();
      chk(pwr_conv == 1'b1, "R3", "conv enable held", pwr_conv, 1);
    end
    tick();
    chk(!pwr_conv && pwr_ro, "R3", "readout enable after conv", pwr_ro, 1);
  endtask

  task automatic wait_end(input int nbits, input bit stray_acq);
    for (int i = 0; i < nbits; i++) begin
      chk(transmit_on == 1'b1, "R5", "transmit window", transmit_on, 1);
      if (stray_acq && i == 2) begin start_acq = 1'b1; tick(); start_acq = 1'b0; end
      else tick();
      if (stray_acq) chk(pwr_acq == 1'b0, "R10", "start_acq ignored in readout", pwr_acq, 0);
    end
    chk(end_readout && !transmit_on, "R7", "end pulse after last bit", end_readout, 1);
    tick();
    chk(!end_readout && !pwr_ro && !pwr_acq && !pwr_conv, "R7", "idle after pass", end_readout, 0);
  endtask

  // monitor: scoreboard compare of serial bits
  always @(negedge clk) begin
    if (!rst) begin
      if (transmit_on) begin
        sess_tx++;
        if (exp_q.size() == 0) chk(1'b0, "R5", "unexpected bit", data_out, -1);
        else begin
          bit e;
          e = exp_q.pop_front();
          chk(data_out == e, "R5", "serial bit", data_out, e);
        end
      end else begin
        chk(data_out == 1'b0, "R6", "line released", data_out, 0);
      end
      if (end_readout) begin
        chk(sess_tx == sess_bits, "R5", "bit count", sess_tx, sess_bits);
        chk(prev_tx == (sess_bits > 0), "R7", "end follows last bit", prev_tx, sess_bits > 0);
        chk(exp_q.size() == 0, "R7", "queue drained", exp_q.size(), 0);
      end
      prev_tx = transmit_on;
    end
  end

  initial begin
    forever begin
      @(posedge clk); cycles++;
      if (cycles > 20000) begin
        errors++; checks++;
        $display("FAIL watchdog: actual %0d expected %0d", cycles, 20000);
        finish_run();
      end
    end
  end

  initial begin
    tick(); tick(); rst = 1'b0; tick();
    // R1 reset state
    chk(!pwr_acq && !pwr_conv && !pwr_ro && !transmit_on && !end_readout && !data_out,
        "R1", "reset outputs", {pwr_acq, pwr_conv, pwr_ro, transmit_on, end_readout}, 0);

    // R3 start_conv in idle ignored; R10 token in idle ignored
    start_conv = 1'b1; tick(); start_conv = 1'b0;
    chk(!pwr_conv && !pwr_acq, "R3", "start_conv ignored in idle", pwr_conv, 0);
    start_readout = 1'b1; tick(); start_readout = 1'b0;
    chk(!end_readout && !transmit_on, "R10", "token ignored in idle", end_readout, 0);
    tick();
    chk(!end_readout, "R10", "no stray pass", end_readout, 0);

    // Session A: three hits, normal token (R2 R4 R5 R7)
    do_hit(8'h11); // idle hit, ignored (R4)
    do_start_acq();
    chk(pwr_acq && !pwr_conv && !pwr_ro, "R2", "acq enable", pwr_acq, 1);
    do_hit(8'hA5); do_hit(8'h3C); do_hit(8'hF0);
    start_readout = 1'b1; tick(); start_readout = 1'b0; // token in acq ignored (R10)
    chk(pwr_acq && !end_readout, "R10", "token ignored in acq", end_readout, 0);
    do_conv(1'b0);
    do_hit(8'h77); // not in acquisition (R4)
    chk(!transmit_on, "R5", "waits for token", transmit_on, 0);
    start_readout = 1'b1; tick(); start_readout = 1'b0;
    wait_end(3 * EVT_W, 1'b0);

    // Session B: overflow and early token, stray start_acq (R4 R9 R10)
    do_start_acq();
    do_hit(8'h01); do_hit(8'h80); do_hit(8'hC3); do_hit(8'h5A); do_hit(8'hFF); do_hit(8'hEE);
    do_conv(1'b1);
    chk(!transmit_on, "R9", "held token waits one cycle", transmit_on, 0);
    tick();
    wait_end(DEPTH * EVT_W, 1'b1);

    // Session C: empty store (R8)
    do_start_acq();
    do_conv(1'b0);
    start_readout = 1'b1; tick(); start_readout = 1'b0;
    chk(end_readout && !transmit_on, "R8", "immediate pass", end_readout, 1);
    tick();
    chk(!end_readout && !pwr_ro, "R8", "idle after pass", end_readout, 0);

    // start_acq accepted again after idle (R10)
    do_start_acq();
    chk(pwr_acq == 1'b1, "R10", "start_acq accepted in idle", pwr_acq, 1);
    tick();
    finish_run();
  end
endmodule